// File: doc/BRIEF.md
# Interleaved Wavefront Issue Scheduler

This block feeds one 16-lane SIMD engine from a pool of resident wavefronts. Each wavefront holds 64 threads, and all of them run the same instruction in lockstep. An instruction therefore occupies the engine for four back-to-back cycles. Each cycle handles one 16-thread quarter, called a beat, and the beat index tells the datapath which lane group is active. When the engine frees up, the scheduler picks the next wavefront in round-robin order from those whose offered instruction is ready.

Every wavefront has a small scoreboard that holds the destinations of its instructions still in the ALU. An ALU result becomes usable eight cycles after its instruction began. An instruction that reads such a register waits until that point. While it waits, any other ready wavefront is issued in the gap, so two wavefronts with dependent code keep the engine fully busy. Two counters record cycles with nothing issued, and the subset of those cycles in which some offered instruction was held back.

The block also reports which work-item sits on lane 0 of the current beat. It numbers work-items linearly with the X index varying fastest, and packs them into wavefronts in that order.

Top module: `wave_issue_sched`

## Requirements
- R1: While reset is high and in the first cycle after it, `issue_valid`, all `instr_ack` bits, `idle_cycles` and `stall_cycles` are zero.
- R2: Each issued instruction holds `issue_valid` high for four consecutive cycles. In those cycles `issue_beat` reads 0, 1, 2, 3 and `issue_wf` stays constant. Beat b covers lanes b*16 to b*16+15 of the wavefront.
- R3: `instr_ack[w]` is high for exactly the beat-0 cycle of each instruction taken from wavefront w, and at most one ack bit is high at a time. Offered instructions are only sampled at a clock edge where the engine is idle or on beat 3.
- R4: An instruction that reads no register still in flight from its own wavefront may begin on the cycle right after the previous instruction of that wavefront finishes beat 3, which is four cycles after that instruction's beat 0.
- R5: An instruction is held if either source register (`instr_src_a` or `instr_src_b`) equals the destination of an instruction from the same wavefront that began fewer than eight cycles earlier. It begins exactly eight cycles after that producer began, if it is selected then. Registers written by other wavefronts never hold it.
- R6: The dependency check covers both instructions of a wavefront that can be in flight at once, the older one as well as the newer one.
- R7: While one wavefront is held, another ready wavefront is issued in the gap. Two wavefronts that each issue a dependent pair keep `issue_valid` high with no idle cycle between their four instructions.
- R8: Selection is round robin, starting at the wavefront after the last one issued and wrapping from 7 to 0. After reset the search starts at wavefront 0.
- R9: Let lin = `issue_wf`*64 + `issue_beat`*16 be the linear index of the lane-0 work-item of the current beat. Then `issue_item_x` = lin mod GROUP_X and `issue_item_y` = lin / GROUP_X, with GROUP_X = 32.
- R10: `idle_cycles` grows by one for each clock edge at which nothing is issued (`issue_valid` low in the following cycle) and saturates at its maximum.
- R11: `stall_cycles` grows by one for each clock edge at which nothing is issued while at least one `instr_valid` bit is high. It saturates, and it never exceeds `idle_cycles`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 8 | Bit w: wavefront w offers an instruction |
| instr_dst | input | 40 | Destination register of wavefront w in bits [w*5 +: 5] |
| instr_src_a | input | 40 | First source register of wavefront w in bits [w*5 +: 5] |
| instr_src_b | input | 40 | Second source register of wavefront w in bits [w*5 +: 5] |
| instr_ack | output | 8 | Bit w pulses in the beat-0 cycle of the instruction taken from wavefront w |
| issue_valid | output | 1 | Engine is executing a beat this cycle |
| issue_wf | output | 3 | Wavefront being executed |
| issue_beat | output | 2 | Quarter (16-lane group) being executed |
| issue_item_x | output | 5 | X index of the lane-0 work-item of this beat |
| issue_item_y | output | 4 | Y index of the lane-0 work-item of this beat |
| idle_cycles | output | 16 | Saturating count of cycles with nothing issued |
| stall_cycles | output | 16 | Saturating count of idle cycles in which an offered instruction was held back |

## Verification
The assertions assume that the instruction a wavefront offers stays stable from one sampling edge to its acknowledgement. They also assume that a new instruction is presented within three cycles of the ack, before the next decision edge. The bench drives each wavefront from a short program and advances to the next entry at the falling edge that follows an ack. The decision edge after beat 3 therefore always sees the updated instruction. The assertions also take it that no source field names a destination on purpose to create a same-wavefront write-after-write overlap. Every program in the bench writes distinct registers, so the fixed eight-cycle latency alone settles result order.

// File: rtl/wave_sched_pkg.sv
package wave_sched_pkg;

  // Number of whole beats needed to cover a latency, rounded up.
  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  // Width of an index over n items, never below one bit.
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/wave_rr_pick.sv
module wave_rr_pick #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] last,
  output logic          found,
  output logic [IW-1:0] pick
);

  logic [IW-1:0] idx;

  // Scan from the slot after the last grant, wrapping once around.
  always_comb begin
    found = 1'b0;
    pick  = '0;
    idx   = '0;
    for (int k = 1; k <= N; k++) begin
      idx = IW'((int'(last) + k) % N);
      if (!found && req[idx]) begin
        found = 1'b1;
        pick  = idx;
      end
    end
  end

endmodule

// File: rtl/wave_scoreboard.sv
module wave_scoreboard #(
  parameter int REG_W   = 5,
  parameter int RAW_LAT = 8,
  parameter int SLOTS   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc,
  input  logic [REG_W-1:0] alloc_dst,
  input  logic [REG_W-1:0] src_a,
  input  logic [REG_W-1:0] src_b,
  output logic             hazard
);

  localparam int TMR_W = wave_sched_pkg::idx_w(RAW_LAT);
  localparam logic [TMR_W-1:0] TMR_LOAD = TMR_W'(RAW_LAT - 1);

  logic [REG_W-1:0] dst_q [SLOTS];
  logic [TMR_W-1:0] tmr_q [SLOTS];
  logic [SLOTS-1:0] busy;
  logic [SLOTS-1:0] take;
  logic             free_any;

  // First free slot receives the next destination.
  always_comb begin
    free_any = 1'b0;
    take     = '0;
    hazard   = 1'b0;
    for (int s = 0; s < SLOTS; s++) begin
      busy[s] = (tmr_q[s] != '0);
      if (!busy[s] && !free_any) begin
        take[s]  = 1'b1;
        free_any = 1'b1;
      end
      if (busy[s] && ((dst_q[s] == src_a) || (dst_q[s] == src_b)))
        hazard = 1'b1;
    end
  end

  // A slot counts down from issue; at zero the result is usable.
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        tmr_q[s] <= '0;
        dst_q[s] <= '0;
      end else if (alloc && take[s]) begin
        tmr_q[s] <= TMR_LOAD;
        dst_q[s] <= alloc_dst;
      end else if (busy[s]) begin
        tmr_q[s] <= tmr_q[s] - 1'b1;
      end
    end
  end

  AST_SLOT_FREE: assert property (@(posedge clk) disable iff (rst)
    alloc |-> free_any);  // R6
  AST_NO_RAW_ISSUE: assert property (@(posedge clk) disable iff (rst)
    alloc |-> !hazard);  // R5

endmodule

// File: rtl/wave_issue_sched.sv
module wave_issue_sched #(
  parameter int NUM_WF  = 8,
  parameter int WF_SIZE = 64,
  parameter int LANES   = 16,
  parameter int REG_W   = 5,
  parameter int RAW_LAT = 8,
  parameter int GROUP_X = 32,
  parameter int CNT_W   = 16
) (
  input  logic                                               clk,
  input  logic                                               rst,
  input  logic [NUM_WF-1:0]                                  instr_valid,
  input  logic [NUM_WF*REG_W-1:0]                            instr_dst,
  input  logic [NUM_WF*REG_W-1:0]                            instr_src_a,
  input  logic [NUM_WF*REG_W-1:0]                            instr_src_b,
  output logic [NUM_WF-1:0]                                  instr_ack,
  output logic                                               issue_valid,
  output logic [$clog2(NUM_WF)-1:0]                          issue_wf,
  output logic [$clog2(WF_SIZE/LANES)-1:0]                   issue_beat,
  output logic [$clog2(GROUP_X)-1:0]                         issue_item_x,
  output logic [$clog2(NUM_WF*WF_SIZE)-$clog2(GROUP_X)-1:0]  issue_item_y,
  output logic [CNT_W-1:0]                                   idle_cycles,
  output logic [CNT_W-1:0]                                   stall_cycles
);

  localparam int BEATS  = WF_SIZE / LANES;
  localparam int BEAT_W = $clog2(BEATS);
  localparam int WF_W   = $clog2(NUM_WF);
  localparam int SLOTS  = wave_sched_pkg::ceil_div(RAW_LAT, BEATS);
  localparam int LIN_W  = $clog2(NUM_WF * WF_SIZE);
  localparam int X_W    = $clog2(GROUP_X);
  localparam int Y_W    = LIN_W - X_W;
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);
  localparam logic [CNT_W-1:0]  CNT_MAX   = '1;
  localparam logic [WF_W-1:0]   WF_LAST   = WF_W'(NUM_WF - 1);

  logic [NUM_WF-1:0] hazard;
  logic [NUM_WF-1:0] ready;
  logic [NUM_WF-1:0] alloc;
  logic [WF_W-1:0]   last_q;
  logic              found;
  logic [WF_W-1:0]   pick;
  logic              engine_free;
  logic [LIN_W-1:0]  lin;

  assign engine_free = !issue_valid || (issue_beat == LAST_BEAT);

  // One dependency scoreboard per resident wavefront.
  for (genvar w = 0; w < NUM_WF; w++) begin : g_wf
    assign alloc[w] = engine_free && found && (pick == WF_W'(w));
    assign ready[w] = instr_valid[w] && !hazard[w];

    wave_scoreboard #(
      .REG_W  (REG_W),
      .RAW_LAT(RAW_LAT),
      .SLOTS  (SLOTS)
    ) u_sb (
      .clk      (clk),
      .rst      (rst),
      .alloc    (alloc[w]),
      .alloc_dst(instr_dst[w*REG_W +: REG_W]),
      .src_a    (instr_src_a[w*REG_W +: REG_W]),
      .src_b    (instr_src_b[w*REG_W +: REG_W]),
      .hazard   (hazard[w])
    );
  end

  wave_rr_pick #(
    .N (NUM_WF),
    .IW(WF_W)
  ) u_pick (
    .req  (ready),
    .last (last_q),
    .found(found),
    .pick (pick)
  );

  // Beat sequencing, selection and counters.
  always_ff @(posedge clk) begin
    if (rst) begin
      issue_valid  <= 1'b0;
      issue_wf     <= '0;
      issue_beat   <= '0;
      last_q       <= WF_LAST;
      instr_ack    <= '0;
      idle_cycles  <= '0;
      stall_cycles <= '0;
    end else begin
      instr_ack <= '0;
      if (!engine_free) begin
        issue_beat <= issue_beat + 1'b1;
      end else if (found) begin
        issue_valid     <= 1'b1;
        issue_beat      <= '0;
        issue_wf        <= pick;
        last_q          <= pick;
        instr_ack[pick] <= 1'b1;
      end else begin
        issue_valid <= 1'b0;
        issue_beat  <= '0;
        if (idle_cycles != CNT_MAX) idle_cycles <= idle_cycles + 1'b1;
        if ((|instr_valid) && (stall_cycles != CNT_MAX))
          stall_cycles <= stall_cycles + 1'b1;
      end
    end
  end

  // Lane-0 work-item of the current beat, X index fastest.
  assign lin          = LIN_W'(int'(issue_wf) * WF_SIZE + int'(issue_beat) * LANES);
  assign issue_item_x = lin[X_W-1:0];
  assign issue_item_y = Y_W'(lin >> X_W);

  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && issue_beat != LAST_BEAT) |=>
      (issue_valid && issue_beat == BEAT_W'($past(issue_beat) + 1'b1)
       && issue_wf == $past(issue_wf)));  // R2
  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(instr_ack));  // R3
  AST_ACK_AT_START: assert property (@(posedge clk) disable iff (rst)
    (|instr_ack) |-> (issue_valid && issue_beat == '0 && instr_ack[issue_wf]));  // R3
  AST_START_ACKED: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && issue_beat == '0) |-> instr_ack[issue_wf]);  // R3
  AST_IDLE_COUNT: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !issue_valid && $past(idle_cycles) != CNT_MAX) |->
      idle_cycles == $past(idle_cycles) + 1'b1);  // R10
  AST_STALL_BOUND: assert property (@(posedge clk) disable iff (rst)
    stall_cycles <= idle_cycles);  // R11

endmodule

// File: tb/wave_issue_sched_tb.sv
module wave_issue_sched_tb;

  localparam int NW = 8;
  localparam int RW = 5;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NW-1:0]  instr_valid = '0;
  logic [NW*RW-1:0] instr_dst = '0, instr_src_a = '0, instr_src_b = '0;
  logic [NW-1:0]  instr_ack;
  logic           issue_valid;
  logic [2:0]     issue_wf;
  logic [1:0]     issue_beat;
  logic [4:0]     issue_item_x;
  logic [3:0]     issue_item_y;
  logic [15:0]    idle_cycles, stall_cycles;

  always #5 clk = ~clk;

  wave_issue_sched u_dut (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_dst(instr_dst),
    .instr_src_a(instr_src_a), .instr_src_b(instr_src_b), .instr_ack(instr_ack),
    .issue_valid(issue_valid), .issue_wf(issue_wf), .issue_beat(issue_beat),
    .issue_item_x(issue_item_x), .issue_item_y(issue_item_y),
    .idle_cycles(idle_cycles), .stall_cycles(stall_cycles)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Instruction word: dst [14:10], src_a [9:5], src_b [4:0].
  function automatic logic [14:0] I(input int d, input int a, input int b);
    return {5'(d), 5'(a), 5'(b)};
  endfunction
  function automatic logic [2:0][14:0] P3(input logic [14:0] i0, i1, i2);
    return {i2, i1, i0};
  endfunction
  function automatic logic [5:0][2:0] W6(input int a, b, c, d, e, f);
    return {3'(f), 3'(e), 3'(d), 3'(c), 3'(b), 3'(a)};
  endfunction
  function automatic logic [5:0][4:0] C6(input int a, b, c, d, e, f);
    return {5'(f), 5'(e), 5'(d), 5'(c), 5'(b), 5'(a)};
  endfunction

  typedef struct packed {
    logic [2:0]       wa;
    logic [2:0]       wb;
    logic [1:0]       na;
    logic [1:0]       nb;
    logic [2:0][14:0] pa;
    logic [2:0][14:0] pb;
    logic [2:0]       ne;
    logic [5:0][2:0]  ewf;
    logic [5:0][4:0]  ec;
    logic [3:0]       stall;
  } row_t;

  localparam int NROWS = 9;
  localparam row_t ROWS [NROWS] = '{
    // R5: dependency through src_a, single wavefront
    '{3'd0, 3'd1, 2'd2, 2'd0, P3(I(1,2,3), I(4,1,5), 15'd0), 45'd0, 3'd2,
      W6(0,0,0,0,0,0), C6(0,8,0,0,0,0), 4'd4},
    // R4: independent pair back to back
    '{3'd0, 3'd1, 2'd2, 2'd0, P3(I(1,2,3), I(4,5,6), 15'd0), 45'd0, 3'd2,
      W6(0,0,0,0,0,0), C6(0,4,0,0,0,0), 4'd0},
    // R7: two dependent wavefronts fill each other's gap
    '{3'd0, 3'd1, 2'd2, 2'd2, P3(I(1,2,3), I(4,1,5), 15'd0), P3(I(7,8,9), I(10,9,7), 15'd0), 3'd4,
      W6(0,1,0,1,0,0), C6(0,4,8,12,0,0), 4'd0},
    // R8 and R5: alternation; a register written by another wavefront does not hold
    '{3'd0, 3'd1, 2'd2, 2'd2, P3(I(3,1,2), I(4,1,2), 15'd0), P3(I(5,3,3), I(6,1,1), 15'd0), 3'd4,
      W6(0,1,0,1,0,0), C6(0,4,8,12,0,0), 4'd0},
    // R5: dependency through src_b
    '{3'd0, 3'd1, 2'd2, 2'd0, P3(I(9,1,2), I(11,4,9), 15'd0), 45'd0, 3'd2,
      W6(0,0,0,0,0,0), C6(0,8,0,0,0,0), 4'd4},
    // R6: third instruction reads the older in-flight result
    '{3'd0, 3'd1, 2'd3, 2'd0, P3(I(5,1,2), I(6,1,2), I(7,5,5)), 45'd0, 3'd3,
      W6(0,0,0,0,0,0), C6(0,4,8,0,0,0), 4'd0},
    // R6: third instruction reads the newer in-flight result
    '{3'd0, 3'd1, 2'd3, 2'd0, P3(I(5,1,2), I(6,1,2), I(7,6,1)), 45'd0, 3'd3,
      W6(0,0,0,0,0,0), C6(0,4,12,0,0,0), 4'd4},
    // R8: search after reset starts at 0, so 2 precedes 6
    '{3'd6, 3'd2, 2'd1, 2'd1, P3(I(1,2,3), 15'd0, 15'd0), P3(I(4,5,6), 15'd0, 15'd0), 3'd2,
      W6(2,6,0,0,0,0), C6(0,4,0,0,0,0), 4'd0},
    // R8: wrap from 7 to 0 and back to 7
    '{3'd7, 3'd0, 2'd2, 2'd1, P3(I(1,2,3), I(4,5,6), 15'd0), P3(I(8,9,10), 15'd0, 15'd0), 3'd3,
      W6(0,7,7,0,0,0), C6(0,4,8,0,0,0), 4'd0}
  };

  int pa_ptr, pb_ptr;
  row_t cur;

  task automatic drive();
    instr_valid = '0;
    if (pa_ptr < int'(cur.na)) begin
      instr_valid[cur.wa] = 1'b1;
      instr_dst[cur.wa*RW +: RW]   = cur.pa[pa_ptr][14:10];
      instr_src_a[cur.wa*RW +: RW] = cur.pa[pa_ptr][9:5];
      instr_src_b[cur.wa*RW +: RW] = cur.pa[pa_ptr][4:0];
    end
    if (pb_ptr < int'(cur.nb)) begin
      instr_valid[cur.wb] = 1'b1;
      instr_dst[cur.wb*RW +: RW]   = cur.pb[pb_ptr][14:10];
      instr_src_a[cur.wb*RW +: RW] = cur.pb[pb_ptr][9:5];
      instr_src_b[cur.wb*RW +: RW] = cur.pb[pb_ptr][4:0];
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    instr_valid = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 valid in reset", int'(issue_valid), 0);
    chk("R1 ack in reset", int'(instr_ack), 0);
    rst = 1'b0;
  endtask

  task automatic run_row(input int r);
    int log_wf[8];
    int log_c[8];
    int n_log = 0;
    int cyc = 0;
    int start = 0;
    int first = -1;
    int lin;
    cur = ROWS[r];
    pa_ptr = 0;
    pb_ptr = 0;
    do_reset();
    drive();
    for (int t = 0; t < 24; t++) begin
      @(negedge clk);
      cyc++;
      if (issue_valid) begin
        if (issue_beat == 2'd0) begin
          if (first < 0) first = cyc;
          if (n_log < 8) begin
            log_wf[n_log] = int'(issue_wf);
            log_c[n_log]  = cyc - first;
          end
          n_log++;
          start = cyc;
          chk("R3 ack at beat 0", int'(instr_ack), 1 << issue_wf);
        end else begin
          chk("R3 no ack after beat 0", int'(instr_ack), 0);
        end
        chk("R2 beat sequence", int'(issue_beat), cyc - start);
        if (n_log > 0 && n_log <= 8) chk("R2 wavefront held", int'(issue_wf), log_wf[n_log-1]);
        lin = int'(issue_wf) * 64 + int'(issue_beat) * 16;
        chk("R9 item x", int'(issue_item_x), lin % 32);
        chk("R9 item y", int'(issue_item_y), lin / 32);
      end else begin
        chk("R3 no ack while idle", int'(instr_ack), 0);
      end
      if (instr_ack[cur.wa] && pa_ptr < int'(cur.na)) pa_ptr++;
      else if (instr_ack[cur.wb] && pb_ptr < int'(cur.nb)) pb_ptr++;
      drive();
    end
    chk("R5 R7 issue count", n_log, int'(cur.ne));
    for (int k = 0; k < int'(cur.ne) && k < n_log; k++) begin
      chk("R4 R5 R6 R7 R8 issue wavefront", log_wf[k], int'(cur.ewf[k]));
      chk("R4 R5 R6 R7 issue start cycle", log_c[k], int'(cur.ec[k]));
    end
    chk("R11 stall count", int'(stall_cycles), int'(cur.stall));
  endtask

  initial begin
    // R1 and R10: reset state, then idle counting with nothing offered
    do_reset();
    chk("R1 idle after reset", int'(idle_cycles), 0);
    chk("R1 stall after reset", int'(stall_cycles), 0);
    repeat (10) @(negedge clk);
    chk("R10 idle count", int'(idle_cycles), 10);
    chk("R11 no stall without offers", int'(stall_cycles), 0);
    chk("R10 valid stays low", int'(issue_valid), 0);
    for (int r = 0; r < NROWS; r++) run_row(r);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule